// File: doc/BRIEF.md
# First-Level Data Cache Request Admission Controller

This block decides, one request per cycle, how a first-level data cache handles a load, store or atomic. It combines the request (address, write flag, atomic flag, access class) with the result of the tag lookup, the state of the miss-tracking table for the target block and the number of free slots in the outbound miss queue. From these it gives a verdict (hit, miss or refused) and a set of action strobes. The strobes tell the surrounding cache to touch the replacement state, mark a line dirty, drop a line, enqueue a store, enqueue a full-line fetch, enqueue a dirty-victim writeback, or record the request in the miss-tracking table.

Store handling depends on three configuration pins. One selects store-through for every store hit. One marks the cache as private to a core, so that global stores that hit go through to memory and the line is dropped, while stores to local data stay in the cache. The third selects whether a store miss allocates a line. A request is accepted only when the miss queue can hold the worst-case number of entries that it could produce. A refused request causes no action at all.

The verdict and strobes are worked out combinationally from the inputs and presented on registered outputs one clock after the request. The strobes are set only in the cycle that reports the decision. The tag array, the miss-tracking table and the queues live outside this block.

Top module: `dcache_policy_ctrl`

## Requirements
- R1: When the tag lookup status is 2 (no line can be allocated), the verdict is refused (code 2) and no strobe is set.
- R2: A store hit (status 0) takes the store-through path when the store-through pin is high, or when the private pin is high and the class is 1 (global store). With at least one free queue slot, the verdict is hit (code 0) with the store-enqueue and line-drop strobes set and no other strobe.
- R3: A store hit on the store-through path with zero free queue slots is refused.
- R4: Any other hit gives verdict hit and touches the replacement state. The line is marked dirty when the request is a store or an atomic; a plain load hit does not mark it dirty.
- R5: A store miss (status 1) with allocation disabled needs at least one free slot. It then gives verdict miss (code 1) with only the store-enqueue strobe set; otherwise it is refused.
- R6: A store miss with allocation enabled needs at least three free slots and a miss-table merge or allocation that can succeed. It then gives verdict miss with store-enqueue set, plus the fetch actions of R8 to R10; otherwise it is refused.
- R7: A load miss needs at least two free slots and a miss-table merge or allocation that can succeed; otherwise it is refused.
- R8: An accepted miss whose block is already tracked (table-hit high, table-room high) is merged. The table-add and replacement strobes are set, and no line fetch or writeback is enqueued.
- R9: An accepted miss whose block is not tracked allocates a table entry only when table-room is high and at least one slot is free. It sets table-add and enqueues a line fetch whose address is the request address with the line-offset bits cleared.
- R10: On a new allocation (R9) with the victim-dirty pin high, a writeback is enqueued whose address equals the victim block address input.
- R11: Results appear one cycle after the request. With no request, response-valid is low and no strobe is set. After reset, response-valid and every strobe are low and the verdict reads refused. No strobe is ever set together with the refused verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqAddr | input | ADDR_W | Request byte address |
| reqWrite | input | 1 | Request is a store |
| reqAtomic | input | 1 | Request is an atomic |
| reqClass | input | 2 | 0 local store, 1 global store, 2 global load, 3 writeback |
| tagStatus | input | 2 | 0 hit, 1 miss, 2 cannot allocate |
| victimDirty | input | 1 | The line picked for replacement is modified |
| victimAddr | input | ADDR_W | Block address of the replacement victim |
| mshrHit | input | 1 | The block is already tracked in the miss table |
| mshrAvail | input | 1 | The miss table can take this request (merge room or free entry) |
| mqFree | input | MQ_CNT_W | Free slots in the miss queue |
| cfgWriteThrough | input | 1 | All store hits go through |
| cfgPrivate | input | 1 | Cache is private to one core |
| cfgWriteAlloc | input | 1 | Store misses allocate a line |
| respValid | output | 1 | A verdict is presented |
| verdict | output | 2 | 0 hit, 1 miss, 2 refused |
| doLruUpdate | output | 1 | Touch replacement state |
| doSetDirty | output | 1 | Mark line modified |
| doInvalidate | output | 1 | Drop the line |
| doPushWrite | output | 1 | Enqueue the store |
| doPushRead | output | 1 | Enqueue a full-line fetch |
| doPushWriteback | output | 1 | Enqueue a victim writeback |
| doAddMshr | output | 1 | Record the request in the miss table |
| writeAddr | output | ADDR_W | Address of the enqueued store |
| readAddr | output | ADDR_W | Line-aligned fetch address |
| writebackAddr | output | ADDR_W | Victim writeback address |

## Verification
The controller is driven with a long run of mixed requests in which the tag status, the policy pins, the miss-table flags and the free-slot count are each varied independently. The free-slot count is kept between zero and five so that every slot threshold is crossed from both sides. Store hits with every class and policy combination separate the store-through path from the write-back path. Misses with each table-hit/room pair separate merging, new allocation and refusal, and a dirty victim separates allocations that add a writeback from those that do not. Idle cycles mixed into the stream confirm that the strobes fall back to zero.

// File: rtl/dcache_policy_pkg.sv
package dcache_policy_pkg;

  typedef enum logic [1:0] {
    VERD_HIT  = 2'd0,
    VERD_MISS = 2'd1,
    VERD_FAIL = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    TAG_HIT     = 2'd0,
    TAG_MISS    = 2'd1,
    TAG_NOALLOC = 2'd2
  } tagSt_e;

  typedef enum logic [1:0] {
    CLS_LOCAL_WR  = 2'd0,
    CLS_GLOBAL_WR = 2'd1,
    CLS_GLOBAL_RD = 2'd2,
    CLS_WRBK      = 2'd3
  } accCls_e;

  typedef struct packed {
    logic lru;
    logic dirty;
    logic inval;
    logic pushWr;
    logic pushRd;
    logic pushWb;
    logic addMshr;
  } actStrb_t;

endpackage

// File: rtl/dcache_policy_decide.sv
module dcache_policy_decide
  import dcache_policy_pkg::*;
#(
  parameter int MQ_CNT_W = 4
) (
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqAtomic,
  input  accCls_e             reqClass,
  input  tagSt_e              tagStatus,
  input  logic                victimDirty,
  input  logic                mshrHit,
  input  logic                mshrAvail,
  input  logic [MQ_CNT_W-1:0] mqFree,
  input  logic                cfgWriteThrough,
  input  logic                cfgPrivate,
  input  logic                cfgWriteAlloc,
  output verdict_e            verdict,
  output actStrb_t            act
);
  // slot needs: single store, load miss (fetch + writeback), allocating store miss
  localparam logic [MQ_CNT_W-1:0] NEED_ONE   = MQ_CNT_W'(1);
  localparam logic [MQ_CNT_W-1:0] NEED_LOAD  = MQ_CNT_W'(2);
  localparam logic [MQ_CNT_W-1:0] NEED_STALL = MQ_CNT_W'(3);

  logic throughPath;
  logic mergeOk;
  logic allocOk;
  logic [MQ_CNT_W-1:0] missNeed;

  always_comb begin
    throughPath = cfgWriteThrough || (cfgPrivate && reqClass == CLS_GLOBAL_WR);
    mergeOk     = mshrHit && mshrAvail;
    allocOk     = !mshrHit && mshrAvail && (mqFree >= NEED_ONE);
    missNeed    = reqWrite ? NEED_STALL : NEED_LOAD;
  end

  always_comb begin
    act     = '0;
    verdict = VERD_FAIL;
    if (reqValid) begin
      unique case (tagStatus)
        TAG_HIT: begin
          if (reqWrite && throughPath) begin
            if (mqFree >= NEED_ONE) begin
              verdict    = VERD_HIT;
              act.pushWr = 1'b1;
              act.inval  = 1'b1;
            end
          end else begin
            verdict   = VERD_HIT;
            act.lru   = 1'b1;
            act.dirty = reqWrite || reqAtomic;
          end
        end
        TAG_MISS: begin
          if (reqWrite && !cfgWriteAlloc) begin
            if (mqFree >= NEED_ONE) begin
              verdict    = VERD_MISS;
              act.pushWr = 1'b1;
            end
          end else if ((mqFree >= missNeed) && (mergeOk || allocOk)) begin
            verdict     = VERD_MISS;
            act.lru     = 1'b1;
            act.addMshr = 1'b1;
            act.pushWr  = reqWrite;
            act.pushRd  = allocOk;
            act.pushWb  = allocOk && victimDirty;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dcache_policy_regs.sv
module dcache_policy_regs
  import dcache_policy_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] victimAddr,
  input  verdict_e          verdictIn,
  input  actStrb_t          actIn,
  output logic              respValid,
  output verdict_e          verdictQ,
  output actStrb_t          actQ,
  output logic [ADDR_W-1:0] writeAddr,
  output logic [ADDR_W-1:0] readAddr,
  output logic [ADDR_W-1:0] writebackAddr
);
  localparam int OFFS_W = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0] lineAddr;
  assign lineAddr = {reqAddr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      verdictQ      <= VERD_FAIL;
      actQ          <= '0;
      writeAddr     <= '0;
      readAddr      <= '0;
      writebackAddr <= '0;
    end else begin
      respValid     <= reqValid;
      verdictQ      <= verdictIn;
      actQ          <= actIn;
      writeAddr     <= reqAddr;
      readAddr      <= lineAddr;
      writebackAddr <= victimAddr;
    end
  end

endmodule

// File: rtl/dcache_policy_ctrl.sv
module dcache_policy_ctrl
  import dcache_policy_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int MQ_CNT_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqAtomic,
  input  logic [1:0]          reqClass,
  input  logic [1:0]          tagStatus,
  input  logic                victimDirty,
  input  logic [ADDR_W-1:0]   victimAddr,
  input  logic                mshrHit,
  input  logic                mshrAvail,
  input  logic [MQ_CNT_W-1:0] mqFree,
  input  logic                cfgWriteThrough,
  input  logic                cfgPrivate,
  input  logic                cfgWriteAlloc,
  output logic                respValid,
  output logic [1:0]          verdict,
  output logic                doLruUpdate,
  output logic                doSetDirty,
  output logic                doInvalidate,
  output logic                doPushWrite,
  output logic                doPushRead,
  output logic                doPushWriteback,
  output logic                doAddMshr,
  output logic [ADDR_W-1:0]   writeAddr,
  output logic [ADDR_W-1:0]   readAddr,
  output logic [ADDR_W-1:0]   writebackAddr
);
  verdict_e verdictComb;
  verdict_e verdictReg;
  actStrb_t actComb;
  actStrb_t actReg;

  dcache_policy_decide #(.MQ_CNT_W(MQ_CNT_W)) decide_i (
    .reqValid        (reqValid),
    .reqWrite        (reqWrite),
    .reqAtomic       (reqAtomic),
    .reqClass        (accCls_e'(reqClass)),
    .tagStatus       (tagSt_e'(tagStatus)),
    .victimDirty     (victimDirty),
    .mshrHit         (mshrHit),
    .mshrAvail       (mshrAvail),
    .mqFree          (mqFree),
    .cfgWriteThrough (cfgWriteThrough),
    .cfgPrivate      (cfgPrivate),
    .cfgWriteAlloc   (cfgWriteAlloc),
    .verdict         (verdictComb),
    .act             (actComb)
  );

  dcache_policy_regs #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) regs_i (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqAddr       (reqAddr),
    .victimAddr    (victimAddr),
    .verdictIn     (verdictComb),
    .actIn         (actComb),
    .respValid     (respValid),
    .verdictQ      (verdictReg),
    .actQ          (actReg),
    .writeAddr     (writeAddr),
    .readAddr      (readAddr),
    .writebackAddr (writebackAddr)
  );

  assign verdict         = verdictReg;
  assign doLruUpdate     = actReg.lru;
  assign doSetDirty      = actReg.dirty;
  assign doInvalidate    = actReg.inval;
  assign doPushWrite     = actReg.pushWr;
  assign doPushRead      = actReg.pushRd;
  assign doPushWriteback = actReg.pushWb;
  assign doAddMshr       = actReg.addMshr;

endmodule

// File: rtl/dcache_policy_chk.sv
module dcache_policy_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int MQ_CNT_W   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqWrite,
  input logic [1:0]          tagStatus,
  input logic                mshrHit,
  input logic                mshrAvail,
  input logic [MQ_CNT_W-1:0] mqFree,
  input logic                cfgWriteThrough,
  input logic                respValid,
  input logic [1:0]          verdict,
  input logic                doLruUpdate,
  input logic                doSetDirty,
  input logic                doInvalidate,
  input logic                doPushWrite,
  input logic                doPushRead,
  input logic                doPushWriteback,
  input logic                doAddMshr
);
  logic [6:0] strb;
  assign strb = {doLruUpdate, doSetDirty, doInvalidate, doPushWrite,
                 doPushRead, doPushWriteback, doAddMshr};

  // R11: a refused verdict carries no action
  p_fail_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (verdict == 2'd2) |-> (strb == '0));

  // R11: no request, no action one cycle later
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && strb == '0));

  // R1: unallocatable probe is refused
  p_noalloc_fail_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && tagStatus == 2'd2) |=> (respValid && verdict == 2'd2));

  // R3: store-through hit without a slot is refused
  p_thru_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && tagStatus == 2'd0 && reqWrite && cfgWriteThrough && mqFree == '0)
      |=> (verdict == 2'd2));

  // R7: load miss with fewer than two slots is refused
  p_load_room_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && tagStatus == 2'd1 && !reqWrite && mqFree < MQ_CNT_W'(2))
      |=> (verdict == 2'd2));

  // R8: merge never fetches nor writes back
  p_merge_nofetch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && tagStatus == 2'd1 && !reqWrite && mshrHit && mshrAvail
       && mqFree >= MQ_CNT_W'(2))
      |=> (doAddMshr && !doPushRead && !doPushWriteback));

  // R10: a writeback only comes with a new line fetch
  p_wb_with_fetch_r10: assert property (@(posedge clk) disable iff (!rstN)
    doPushWriteback |-> doPushRead);

  // R2: dropping a line never also dirties it
  p_drop_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    doInvalidate |-> (!doSetDirty && !doLruUpdate && doPushWrite));

endmodule

bind dcache_policy_ctrl dcache_policy_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MQ_CNT_W(MQ_CNT_W)
) chk_i (
  .clk             (clk),
  .rstN            (rstN),
  .reqValid        (reqValid),
  .reqWrite        (reqWrite),
  .tagStatus       (tagStatus),
  .mshrHit         (mshrHit),
  .mshrAvail       (mshrAvail),
  .mqFree          (mqFree),
  .cfgWriteThrough (cfgWriteThrough),
  .respValid       (respValid),
  .verdict         (verdict),
  .doLruUpdate     (doLruUpdate),
  .doSetDirty      (doSetDirty),
  .doInvalidate    (doInvalidate),
  .doPushWrite     (doPushWrite),
  .doPushRead      (doPushRead),
  .doPushWriteback (doPushWriteback),
  .doAddMshr       (doAddMshr)
);

// File: tb/dcache_policy_ctrl_tb_top.sv
module dcache_policy_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int LINE_BYTES = 128;
  localparam int MQ_CNT_W   = 4;
  localparam int N_RAND     = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                reqValid = 0, reqWrite = 0, reqAtomic = 0;
  logic [ADDR_W-1:0]   reqAddr = '0, victimAddr = '0;
  logic [1:0]          reqClass = '0, tagStatus = '0;
  logic                victimDirty = 0, mshrHit = 0, mshrAvail = 0;
  logic [MQ_CNT_W-1:0] mqFree = '0;
  logic                cfgWriteThrough = 0, cfgPrivate = 0, cfgWriteAlloc = 0;
  logic                respValid;
  logic [1:0]          verdict;
  logic doLruUpdate, doSetDirty, doInvalidate, doPushWrite, doPushRead,
        doPushWriteback, doAddMshr;
  logic [ADDR_W-1:0] writeAddr, readAddr, writebackAddr;

  dcache_policy_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MQ_CNT_W(MQ_CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqAtomic(reqAtomic), .reqClass(reqClass),
    .tagStatus(tagStatus), .victimDirty(victimDirty), .victimAddr(victimAddr),
    .mshrHit(mshrHit), .mshrAvail(mshrAvail), .mqFree(mqFree),
    .cfgWriteThrough(cfgWriteThrough), .cfgPrivate(cfgPrivate),
    .cfgWriteAlloc(cfgWriteAlloc), .respValid(respValid), .verdict(verdict),
    .doLruUpdate(doLruUpdate), .doSetDirty(doSetDirty), .doInvalidate(doInvalidate),
    .doPushWrite(doPushWrite), .doPushRead(doPushRead),
    .doPushWriteback(doPushWriteback), .doAddMshr(doAddMshr),
    .writeAddr(writeAddr), .readAddr(readAddr), .writebackAddr(writebackAddr)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // expected response (strobes ordered lru,dirty,inval,wr,rd,wb,add)
  logic        eValid;
  logic [1:0]  eVerd;
  logic [6:0]  eStrb;
  logic [ADDR_W-1:0] eWrA, eRdA, eWbA;
  string       eTag;
  bit          havePrev = 0;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: how many slots the request can demand, then which actions
  task automatic predict();
    int slots;
    bit lru, drt, inv, wr, rd, wb, add, accept, miss, merge, fresh;
    lru = 0; drt = 0; inv = 0; wr = 0; rd = 0; wb = 0; add = 0;
    accept = 0; miss = 0;
    slots = int'(mqFree);
    merge = mshrHit && mshrAvail;
    fresh = !mshrHit && mshrAvail && slots > 0;
    eTag  = "R11";
    if (reqValid) begin
      if (tagStatus == 2'd2) eTag = "R1";
      else if (tagStatus == 2'd0) begin
        if (reqWrite && (cfgWriteThrough || (cfgPrivate && reqClass == 2'd1))) begin
          eTag = (slots > 0) ? "R2" : "R3";
          if (slots > 0) begin accept = 1; wr = 1; inv = 1; end
        end else begin
          eTag = "R4"; accept = 1; lru = 1;
          if (reqWrite || reqAtomic) drt = 1;
        end
      end else if (tagStatus == 2'd1) begin
        miss = 1;
        if (reqWrite && !cfgWriteAlloc) begin
          eTag = "R5";
          if (slots >= 1) begin accept = 1; wr = 1; end
        end else begin
          eTag = reqWrite ? "R6" : "R7";
          if (slots >= (reqWrite ? 3 : 2) && (merge || fresh)) begin
            accept = 1; lru = 1; add = 1; wr = reqWrite;
            if (merge) eTag = "R8";
            else begin
              rd = 1; eTag = "R9";
              if (victimDirty) begin wb = 1; eTag = "R10"; end
            end
          end
        end
      end
    end
    eValid = reqValid;
    eVerd  = !accept ? 2'd2 : (miss ? 2'd1 : 2'd0);
    eStrb  = {lru, drt, inv, wr, rd, wb, add};
    eWrA   = reqAddr;
    eRdA   = reqAddr & ~ADDR_W'(LINE_BYTES - 1);
    eWbA   = victimAddr;
  endtask

  task automatic compare();
    logic [6:0] got;
    got = {doLruUpdate, doSetDirty, doInvalidate, doPushWrite, doPushRead,
           doPushWriteback, doAddMshr};
    check(eTag, "respValid", respValid, eValid);
    check(eTag, "verdict", verdict, eVerd);
    check(eTag, "strobes", got, eStrb);
    if (eStrb[3]) check(eTag, "writeAddr", writeAddr, eWrA);
    if (eStrb[2]) check(eTag, "readAddr", readAddr, eRdA);
    if (eStrb[1]) check(eTag, "writebackAddr", writebackAddr, eWbA);
  endtask

  // one request per cycle: drive at negedge, compare the previous one at the same time
  task automatic issue(input bit v, input bit w, input bit at, input logic [1:0] cls,
                       input logic [1:0] ts, input bit vd, input bit mh, input bit ma,
                       input int free, input bit wt, input bit pv, input bit wa,
                       input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] va);
    @(negedge clk);
    if (havePrev) compare();
    reqValid = v; reqWrite = w; reqAtomic = at; reqClass = cls; tagStatus = ts;
    victimDirty = vd; mshrHit = mh; mshrAvail = ma; mqFree = MQ_CNT_W'(free);
    cfgWriteThrough = wt; cfgPrivate = pv; cfgWriteAlloc = wa;
    reqAddr = a; victimAddr = va;
    predict();
    havePrev = 1;
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, 100000);
      finishUp();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11", "reset respValid", respValid, 0);
    check("R11", "reset verdict", verdict, 2);
    check("R11", "reset strobes", {doLruUpdate, doSetDirty, doInvalidate, doPushWrite,
          doPushRead, doPushWriteback, doAddMshr}, 0);
    rstN = 1;
    // directed corners
    issue(1,0,0,2'd2,2'd2,0,0,1,5,0,0,0,32'h1000,32'h0);        // R1
    issue(1,1,0,2'd1,2'd0,0,0,0,1,0,1,0,32'h1234,32'h0);        // R2 private global store
    issue(1,1,0,2'd0,2'd0,0,0,0,0,0,1,0,32'h1234,32'h0);        // R4 private local store stays back
    issue(1,1,0,2'd1,2'd0,0,0,0,0,1,0,0,32'h2000,32'h0);        // R3
    issue(1,0,1,2'd2,2'd0,0,0,0,0,0,0,0,32'h2040,32'h0);        // R4 atomic load
    issue(1,1,0,2'd0,2'd1,0,0,0,1,0,0,0,32'h3004,32'h0);        // R5
    issue(1,1,0,2'd0,2'd1,1,0,1,2,0,0,1,32'h3008,32'h0);        // R6 refused at 2
    issue(1,1,0,2'd0,2'd1,1,0,1,3,0,0,1,32'h300C,32'h7700);     // R6 accepted + R10
    issue(1,0,0,2'd2,2'd1,0,1,1,1,0,0,0,32'h4010,32'h0);        // R7 one slot
    issue(1,0,0,2'd2,2'd1,1,1,1,2,0,0,0,32'h4010,32'h8800);     // R8 merge
    issue(1,0,0,2'd2,2'd1,0,0,0,4,0,0,0,32'h4090,32'h0);        // R9 no table room
    issue(1,0,0,2'd2,2'd1,0,0,1,2,0,0,0,32'h40FF,32'h0);        // R9 fetch, clean victim
    issue(1,0,0,2'd2,2'd1,1,0,1,2,0,0,0,32'h41FF,32'h9980);     // R10
    issue(0,1,1,2'd1,2'd1,1,0,1,5,1,1,1,32'h5000,32'h0);        // R11 idle
    for (int i = 0; i < N_RAND; i++) begin
      issue(($urandom_range(0,7) != 0), $urandom_range(0,1), ($urandom_range(0,3) == 0),
            2'($urandom_range(0,3)), 2'($urandom_range(0,2)), $urandom_range(0,1),
            $urandom_range(0,1), ($urandom_range(0,3) != 0), $urandom_range(0,5),
            $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
            $urandom, $urandom);
    end
    issue(0,0,0,2'd0,2'd0,0,0,0,0,0,0,0,32'h0,32'h0);
    @(negedge clk);
    compare();
    finishUp();
  end

endmodule